// File: doc/BRIEF.md
# Monochrome Expansion Rectangle Writer

This block fills an axis-aligned rectangle of pixels, one pixel per clock, and produces a write request for each one. A command gives the origin, the width and height as count minus one, the direction of travel on each axis, two colors, two mix settings, a pixel-control mode and a per-bit write mask. For every pixel the block picks one of the two mixes. The chosen mix names a source and a raster operation. The operation combines that source with the pixel already in memory. The masked result is then issued as the write data.

Text and glyph drawing uses host-data mode. A stream of 16-bit host words supplies one bit per pixel, most significant bit first. A 1 bit selects the foreground mix and a 0 bit selects the background mix. Each row starts on a fresh word, and the unused tail of a row's last word is thrown away. The existing pixel at the current write coordinate comes back through a combinational read port. Each write then becomes a complete merged pixel value.

Top module: `mex_rect_expand`

## Requirements
- R1: While reset is held and after it is released, busy_o, wr_en_o and host_ready_o are all low.
- R2: A start_i pulse while idle latches every command input. busy_o rises on the next edge and falls on the edge that writes the last pixel. A new start is accepted in the cycle right after that. A start while busy is ignored.
- R3: The rectangle covers width_m1_i+1 columns by height_m1_i+1 rows. Writes go one per cycle in row order: the column index runs fully, then the row index advances. Each coordinate moves away from the origin, increasing when its direction input is 1 and decreasing when it is 0.
- R4: Pixel control 2'b00 applies the foreground mix to every pixel. The value 2'b11 does the same.
- R5: Pixel control 2'b01 takes one host bit per pixel, MSB first. A 1 bit applies the foreground mix and a 0 bit the background mix. Each row takes ceil(width/16) words, and trailing bits of a row's last word are dropped. host_ready_o is high only while no unconsumed word is held, or in the cycle that consumes the held word's last needed bit.
- R6: Pixel control 2'b10 uses bit 0 of the existing destination pixel as the selector: 1 applies the foreground mix, 0 the background mix.
- R7: A mix is 7 bits. Bits 6:5 select the source: 00 background color, 01 foreground color, 10 the current host bit expanded to every bit (all zeros outside host-data mode), 11 the destination pixel. Bits 4:0 select the raster operation.
- R8: Raster operation codes (s source, d destination) are: 00 ~d, 01 zero, 02 ones, 03 d, 04 ~s, 05 s^d, 06 ~s&d, 07 s, 08 ~(s&d), 09 ~(s|d), 0A ~(s^d), 0B ~s|d, 0C s&d, 0D s&~d, 0E s|d, 0F s|~d. Any other code leaves d.
- R9: The write data keeps the destination bits where the write mask is 0 and takes the operation result where it is 1. wr_mask_o carries the latched mask.
- R10: In every pixel-control mode other than 2'b01, host_ready_o stays low and host words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start strobe |
| origin_x_i | input | COORD_W | First column |
| origin_y_i | input | COORD_W | First row |
| dir_x_pos_i | input | 1 | 1: columns increase, 0: decrease |
| dir_y_pos_i | input | 1 | 1: rows increase, 0: decrease |
| width_m1_i | input | CNT_W | Columns minus one |
| height_m1_i | input | CNT_W | Rows minus one |
| fg_color_i | input | PIX_W | Foreground color |
| bg_color_i | input | PIX_W | Background color |
| fg_mix_i | input | 7 | Foreground mix: source 6:5, operation 4:0 |
| bg_mix_i | input | 7 | Background mix: source 6:5, operation 4:0 |
| pix_ctrl_i | input | 2 | Mix selection mode |
| wr_mask_i | input | PIX_W | Bits of a pixel that may change |
| host_word_i | input | WORD_W | Host bitmap word |
| host_valid_i | input | 1 | Host word offered |
| host_ready_o | output | 1 | Host word taken when valid |
| dst_rd_data_i | input | PIX_W | Current contents at wr_x_o/wr_y_o |
| wr_en_o | output | 1 | Pixel write this cycle |
| wr_x_o | output | COORD_W | Write column |
| wr_y_o | output | COORD_W | Write row |
| wr_data_o | output | PIX_W | Merged pixel value |
| wr_mask_o | output | PIX_W | Latched write mask |
| busy_o | output | 1 | Command in progress |

## Verification
The bench targets a 20-pixel row whose second word carries set trailing bits. A design that consumed those bits would shift every later row by twelve pixels and corrupt the second row. Each raster code is run against a fixed source and destination pair, so a swapped operand or a missing complement shows up as a distinct wrong value. Decreasing-direction fills catch a walker that ignores the direction bits or shifts the rectangle by one. A start pulse fired in the middle of a command and back-to-back commands catch a design that relatches its settings, or that needs an idle cycle before it takes the next command. Destination-selected mode with a partial mask checks that the selector bit and the untouched high bits both come from the old pixel.

// File: rtl/mex_pkg.sv
`timescale 1ns/1ps
package mex_pkg;
  typedef enum logic [1:0] {
    SRC_BG   = 2'b00,
    SRC_FG   = 2'b01,
    SRC_HOST = 2'b10,
    SRC_DST  = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    PC_FG_ONLY = 2'b00,
    PC_HOST    = 2'b01,
    PC_DST     = 2'b10,
    PC_RSVD    = 2'b11
  } pix_ctrl_e;

  typedef struct packed {
    src_sel_e   src;
    logic [4:0] rop;
  } mix_t;
endpackage

// File: rtl/mex_walker.sv
`timescale 1ns/1ps
module mex_walker #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] w_m1_i,
  input  logic [CNT_W-1:0] h_m1_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] col_o,
  output logic [CNT_W-1:0] row_o,
  output logic             row_end_o,
  output logic             rect_end_o
);
  logic             busy_q;
  logic [CNT_W-1:0] col_q, row_q;
  logic             last_col, last_row;

  assign last_col   = (col_q == w_m1_i);
  assign last_row   = (row_q == h_m1_i);
  assign row_end_o  = step_i & last_col;
  assign rect_end_o = row_end_o & last_row;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      col_q  <= '0;
      row_q  <= '0;
    end else if (step_i) begin
      if (last_col) begin
        col_q <= '0;
        if (last_row) busy_q <= 1'b0;
        else          row_q  <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign col_o  = col_q;
  assign row_o  = row_q;
endmodule

// File: rtl/mex_bitfeed.sv
`timescale 1ns/1ps
module mex_bitfeed #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              busy_i,
  input  logic              host_mode_i,
  input  logic              step_i,
  input  logic              row_end_i,
  input  logic              rect_end_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              have_o,
  output logic              bit_o
);
  localparam int IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] bits_q;
  logic [IDX_W-1:0]  idx_q;
  logic              have_q;
  logic              word_done;

  // word retires on its last bit or at row end (tail dropped)
  assign word_done = step_i & have_q &
                     ((idx_q == IDX_W'(WORD_W - 1)) | row_end_i);
  assign ready_o   = busy_i & host_mode_i &
                     (~have_q | (word_done & ~rect_end_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      idx_q  <= '0;
      have_q <= 1'b0;
    end else if (clear_i) begin
      have_q <= 1'b0;
      idx_q  <= '0;
    end else if (valid_i && ready_o) begin
      bits_q <= word_i;
      idx_q  <= '0;
      have_q <= 1'b1;
    end else if (word_done) begin
      have_q <= 1'b0;
    end else if (step_i && have_q) begin
      bits_q <= {bits_q[WORD_W-2:0], 1'b0};
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign have_o = have_q;
  assign bit_o  = bits_q[WORD_W-1];
endmodule

// File: rtl/mex_mix.sv
`timescale 1ns/1ps
module mex_mix
  import mex_pkg::*;
#(
  parameter int PIX_W = 16
) (
  input  mix_t             fg_mix_i,
  input  mix_t             bg_mix_i,
  input  logic             use_fg_i,
  input  logic [PIX_W-1:0] fg_color_i,
  input  logic [PIX_W-1:0] bg_color_i,
  input  logic             host_bit_i,
  input  logic             host_mode_i,
  input  logic [PIX_W-1:0] dst_i,
  input  logic [PIX_W-1:0] mask_i,
  output logic [PIX_W-1:0] data_o
);
  mix_t             mix;
  logic [PIX_W-1:0] s, d, res;

  assign mix = use_fg_i ? fg_mix_i : bg_mix_i;
  assign d   = dst_i;

  always_comb begin
    unique case (mix.src)
      SRC_BG:   s = bg_color_i;
      SRC_FG:   s = fg_color_i;
      SRC_HOST: s = {PIX_W{host_bit_i & host_mode_i}};
      default:  s = dst_i;
    endcase
  end

  always_comb begin
    case (mix.rop)
      5'h00:   res = ~d;
      5'h01:   res = '0;
      5'h02:   res = '1;
      5'h03:   res = d;
      5'h04:   res = ~s;
      5'h05:   res = s ^ d;
      5'h06:   res = ~s & d;
      5'h07:   res = s;
      5'h08:   res = ~(s & d);
      5'h09:   res = ~(s | d);
      5'h0A:   res = ~(s ^ d);
      5'h0B:   res = ~s | d;
      5'h0C:   res = s & d;
      5'h0D:   res = s & ~d;
      5'h0E:   res = s | d;
      5'h0F:   res = s | ~d;
      default: res = d;
    endcase
  end

  assign data_o = (d & ~mask_i) | (res & mask_i);
endmodule

// File: rtl/mex_rect_expand.sv
`timescale 1ns/1ps
module mex_rect_expand
  import mex_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int CNT_W   = 12,
  parameter int PIX_W   = 16,
  parameter int WORD_W  = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] origin_x_i,
  input  logic [COORD_W-1:0] origin_y_i,
  input  logic               dir_x_pos_i,
  input  logic               dir_y_pos_i,
  input  logic [CNT_W-1:0]   width_m1_i,
  input  logic [CNT_W-1:0]   height_m1_i,
  input  logic [PIX_W-1:0]   fg_color_i,
  input  logic [PIX_W-1:0]   bg_color_i,
  input  logic [6:0]         fg_mix_i,
  input  logic [6:0]         bg_mix_i,
  input  logic [1:0]         pix_ctrl_i,
  input  logic [PIX_W-1:0]   wr_mask_i,
  input  logic [WORD_W-1:0]  host_word_i,
  input  logic               host_valid_i,
  output logic               host_ready_o,
  input  logic [PIX_W-1:0]   dst_rd_data_i,
  output logic               wr_en_o,
  output logic [COORD_W-1:0] wr_x_o,
  output logic [COORD_W-1:0] wr_y_o,
  output logic [PIX_W-1:0]   wr_data_o,
  output logic [PIX_W-1:0]   wr_mask_o,
  output logic               busy_o
);
  logic [COORD_W-1:0] ox_q, oy_q;
  logic               dx_q, dy_q;
  logic [CNT_W-1:0]   wm1_q, hm1_q;
  logic [PIX_W-1:0]   fg_q, bg_q, mask_q;
  mix_t               fmix_q, bmix_q;
  pix_ctrl_e          pc_q;

  logic               busy, start_acc, step, host_mode;
  logic [CNT_W-1:0]   col, row;
  logic               row_end, rect_end;
  logic               have, hbit, use_fg;
  logic [COORD_W-1:0] off_x, off_y;

  assign start_acc = start_i & ~busy;
  assign host_mode = (pc_q == PC_HOST);
  assign step      = busy & (~host_mode | have);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ox_q   <= '0;
      oy_q   <= '0;
      dx_q   <= 1'b1;
      dy_q   <= 1'b1;
      wm1_q  <= '0;
      hm1_q  <= '0;
      fg_q   <= '0;
      bg_q   <= '0;
      mask_q <= '0;
      fmix_q <= '0;
      bmix_q <= '0;
      pc_q   <= PC_FG_ONLY;
    end else if (start_acc) begin
      ox_q   <= origin_x_i;
      oy_q   <= origin_y_i;
      dx_q   <= dir_x_pos_i;
      dy_q   <= dir_y_pos_i;
      wm1_q  <= width_m1_i;
      hm1_q  <= height_m1_i;
      fg_q   <= fg_color_i;
      bg_q   <= bg_color_i;
      mask_q <= wr_mask_i;
      fmix_q <= mix_t'(fg_mix_i);
      bmix_q <= mix_t'(bg_mix_i);
      pc_q   <= pix_ctrl_e'(pix_ctrl_i);
    end
  end

  mex_walker #(.CNT_W(CNT_W)) u_walk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_acc),
    .step_i     (step),
    .w_m1_i     (wm1_q),
    .h_m1_i     (hm1_q),
    .busy_o     (busy),
    .col_o      (col),
    .row_o      (row),
    .row_end_o  (row_end),
    .rect_end_o (rect_end)
  );

  mex_bitfeed #(.WORD_W(WORD_W)) u_feed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start_acc),
    .busy_i      (busy),
    .host_mode_i (host_mode),
    .step_i      (step),
    .row_end_i   (row_end),
    .rect_end_i  (rect_end),
    .word_i      (host_word_i),
    .valid_i     (host_valid_i),
    .ready_o     (host_ready_o),
    .have_o      (have),
    .bit_o       (hbit)
  );

  always_comb begin
    unique case (pc_q)
      PC_HOST: use_fg = hbit;
      PC_DST:  use_fg = dst_rd_data_i[0];
      default: use_fg = 1'b1;
    endcase
  end

  mex_mix #(.PIX_W(PIX_W)) u_mix (
    .fg_mix_i    (fmix_q),
    .bg_mix_i    (bmix_q),
    .use_fg_i    (use_fg),
    .fg_color_i  (fg_q),
    .bg_color_i  (bg_q),
    .host_bit_i  (hbit),
    .host_mode_i (host_mode),
    .dst_i       (dst_rd_data_i),
    .mask_i      (mask_q),
    .data_o      (wr_data_o)
  );

  assign off_x     = COORD_W'(col);
  assign off_y     = COORD_W'(row);
  assign wr_x_o    = dx_q ? ox_q + off_x : ox_q - off_x;
  assign wr_y_o    = dy_q ? oy_q + off_y : oy_q - off_y;
  assign wr_en_o   = step;
  assign wr_mask_o = mask_q;
  assign busy_o    = busy;
endmodule

// File: rtl/mex_checker.sv
`timescale 1ns/1ps
module mex_checker #(
  parameter int PIX_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             wr_en_o,
  input logic             host_ready_o,
  input logic             host_mode,
  input logic [PIX_W-1:0] wr_data_o,
  input logic [PIX_W-1:0] wr_mask_o,
  input logic [PIX_W-1:0] dst_rd_data_i
);
  a_r2_write_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r2_done_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(wr_en_o));

  a_r5_ready_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |-> busy_o);

  a_r10_no_ready_other_modes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_ready_o |-> host_mode);

  a_r9_mask_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (((wr_data_o ^ dst_rd_data_i) & ~wr_mask_o) == '0));
endmodule

bind mex_rect_expand mex_checker #(.PIX_W(PIX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .wr_en_o       (wr_en_o),
  .host_ready_o  (host_ready_o),
  .host_mode     (host_mode),
  .wr_data_o     (wr_data_o),
  .wr_mask_o     (wr_mask_o),
  .dst_rd_data_i (dst_rd_data_i)
);

// File: tb/mex_rect_expand_test.sv
`timescale 1ns/1ps
module mex_rect_expand_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] ox = '0, oy = '0;
  logic        dxp = 1'b1, dyp = 1'b1;
  logic [11:0] wm1 = '0, hm1 = '0;
  logic [15:0] fg = '0, bg = '0, mask = 16'hFFFF;
  logic [6:0]  fmix = '0, bmix = '0;
  logic [1:0]  pc = 2'b00;
  logic [15:0] hword = '0;
  logic        hvalid = 1'b0;
  logic        hready, wr_en, busy;
  logic [11:0] wx, wy;
  logic [15:0] wdata, wmask, rd;

  logic [15:0] mem [0:15][0:31];
  logic [15:0] expm [0:15][0:31];
  logic [15:0] hw [0:7];

  int checks = 0;
  int errors = 0;
  int busy_cycles, ready_seen, first_busy;

  always #2.5 clk = ~clk;

  assign rd = mem[wy[3:0]][wx[4:0]];
  always @(posedge clk) if (wr_en) mem[wy[3:0]][wx[4:0]] <= wdata;

  mex_rect_expand uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .origin_x_i(ox), .origin_y_i(oy), .dir_x_pos_i(dxp), .dir_y_pos_i(dyp),
    .width_m1_i(wm1), .height_m1_i(hm1),
    .fg_color_i(fg), .bg_color_i(bg), .fg_mix_i(fmix), .bg_mix_i(bmix),
    .pix_ctrl_i(pc), .wr_mask_i(mask),
    .host_word_i(hword), .host_valid_i(hvalid), .host_ready_o(hready),
    .dst_rd_data_i(rd), .wr_en_o(wr_en), .wr_x_o(wx), .wr_y_o(wy),
    .wr_data_o(wdata), .wr_mask_o(wmask), .busy_o(busy)
  );

  // {req, mix, mask, expected}; fg F0F0, bg 1234, dst CCCC
  localparam logic [42:0] VEC [0:14] = '{
    {4'd8, 7'h20, 16'hFFFF, 16'h3333},
    {4'd8, 7'h21, 16'hFFFF, 16'h0000},
    {4'd8, 7'h22, 16'hFFFF, 16'hFFFF},
    {4'd8, 7'h23, 16'hFFFF, 16'hCCCC},
    {4'd8, 7'h24, 16'hFFFF, 16'h0F0F},
    {4'd8, 7'h25, 16'hFFFF, 16'h3C3C},
    {4'd8, 7'h26, 16'hFFFF, 16'h0C0C},
    {4'd8, 7'h27, 16'hFFFF, 16'hF0F0},
    {4'd8, 7'h2B, 16'hFFFF, 16'hCFCF},
    {4'd8, 7'h2C, 16'hFFFF, 16'hC0C0},
    {4'd8, 7'h2E, 16'hFFFF, 16'hFCFC},
    {4'd9, 7'h27, 16'h00FF, 16'hCCF0},
    {4'd7, 7'h07, 16'hFFFF, 16'h1234},
    {4'd7, 7'h65, 16'hFFFF, 16'h0000},
    {4'd7, 7'h47, 16'hFFFF, 16'h0000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    int by = 0, bx = 0;
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 32; x++)
        if (mem[y][x] !== expm[y][x]) begin
          if (bad == 0) begin by = y; bx = x; end
          bad++;
        end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: pixel (%0d,%0d) actual %h expected %h, %0d bad",
               tag, bx, by, mem[by][bx], expm[by][bx], bad);
    end
  endtask

  task automatic clear_mem(input logic [15:0] v);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 32; x++) begin
        mem[y][x] <= v;
        expm[y][x] = v;
      end
    @(negedge clk);
  endtask

  // start at a negedge, feed nw host words, return at first idle negedge
  task automatic run_cmd(input int nw, input bit spam, input bit poke);
    int i = 0;
    int guard = 0;
    bit took;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_cycles = 0;
    ready_seen = 0;
    first_busy = busy;
    while ((i < nw || busy) && guard < 4000) begin
      if (i < nw) begin hvalid = 1'b1; hword = hw[i]; end
      else begin hvalid = spam; hword = 16'hFFFF; end
      if (poke && guard == 2) begin start = 1'b1; ox = 12'd0; end
      else start = 1'b0;
      #1;
      took = hvalid && hready;
      if (busy) busy_cycles++;
      if (hready) ready_seen++;
      @(negedge clk);
      if (took && i < nw) i++;
      guard++;
    end
    start = 1'b0;
    hvalid = 1'b0;
    if (guard >= 4000) begin
      checks++;
      errors++;
      $display("FAIL R2: command did not finish, actual busy %0d expected 0", busy);
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 32; x++) begin
        mem[y][x] <= '0;
        expm[y][x] = '0;
      end
    repeat (3) @(negedge clk);
    // R1: reset state, held and released
    check("R1 busy in reset", {15'd0, busy}, 16'd0);
    check("R1 wr_en in reset", {15'd0, wr_en}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", {15'd0, hready}, 16'd0);
    check("R1 busy after reset", {15'd0, busy}, 16'd0);

    // R7 R8 R9 table: single pixel at (3,2), pixel control 00
    for (int v = 0; v < 15; v++) begin
      clear_mem(16'h0000);
      mem[2][3] <= 16'hCCCC;
      @(negedge clk);
      ox = 12'd3; oy = 12'd2; wm1 = 0; hm1 = 0; dxp = 1; dyp = 1;
      fg = 16'hF0F0; bg = 16'h1234; pc = 2'b00;
      fmix = VEC[v][38:32]; bmix = 7'h22; mask = VEC[v][31:16];
      run_cmd(0, 0, 0);
      check($sformatf("R%0d vector %0d", VEC[v][42:39], v), mem[2][3], VEC[v][15:0]);
    end

    // R3 R4: 5x3 fill, both directions negative, mid-run start poke (R2)
    clear_mem(16'h1111);
    ox = 12'd10; oy = 12'd8; dxp = 0; dyp = 0; wm1 = 4; hm1 = 2;
    fg = 16'hBEEF; bg = 16'h0; fmix = 7'h27; bmix = 7'h21; mask = 16'hFFFF; pc = 2'b00;
    for (int y = 6; y <= 8; y++)
      for (int x = 6; x <= 10; x++) expm[y][x] = 16'hBEEF;
    run_cmd(0, 1, 1);
    check_mem("R3 negative-direction fill");
    check("R2 busy cycles 5x3", 16'(busy_cycles), 16'd15);
    check("R10 ready during fg-only fill", 16'(ready_seen), 16'd0);

    // R2: back-to-back, next command accepted the cycle after completion
    // R4: pixel control 11 behaves as foreground only
    ox = 12'd20; oy = 12'd12; dxp = 1; dyp = 1; wm1 = 1; hm1 = 1;
    fmix = 7'h22; bmix = 7'h21; pc = 2'b11;
    for (int y = 12; y <= 13; y++)
      for (int x = 20; x <= 21; x++) expm[y][x] = 16'hFFFF;
    run_cmd(0, 1, 0);
    check("R2 back-to-back start taken", 16'(first_busy), 16'd1);
    check_mem("R4 pixel control 11 fill");
    check("R10 ready in mode 11", 16'(ready_seen), 16'd0);

    // R5: host expansion, 20 wide x 2 rows, trailing bits set
    clear_mem(16'h0000);
    hw[0] = 16'hA5C3; hw[1] = 16'hF0FF; hw[2] = 16'h0001; hw[3] = 16'h9FFF;
    ox = 12'd4; oy = 12'd1; wm1 = 19; hm1 = 1;
    fg = 16'hAAAA; bg = 16'h5555; fmix = 7'h27; bmix = 7'h07; pc = 2'b01;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 20; c++)
        expm[1 + r][4 + c] = hw[r * 2 + c / 16][15 - c % 16] ? 16'hAAAA : 16'h5555;
    run_cmd(4, 0, 0);
    check_mem("R5 host expansion 20x2");
    check("R5 busy cycles 20x2", 16'(busy_cycles >= 40), 16'd1);

    // R5 R7: width 16, one word per row, host bit as source
    clear_mem(16'h0F0F);
    hw[0] = 16'h8001; hw[1] = 16'h7FFE;
    ox = 12'd0; oy = 12'd10; wm1 = 15; hm1 = 1;
    fmix = 7'h47; bmix = 7'h45; pc = 2'b01;
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 16; c++)
        expm[10 + r][c] = hw[r][15 - c] ? 16'hFFFF : 16'h0F0F;
    run_cmd(2, 0, 0);
    check_mem("R5 width 16 host source");

    // R6: destination bit 0 selects, partial mask
    clear_mem(16'h0000);
    for (int y = 3; y <= 5; y++)
      for (int x = 8; x <= 11; x++) begin
        mem[y][x] <= ((x + y) % 2 == 1) ? 16'hA003 : 16'hA002;
        expm[y][x] = ((x + y) % 2 == 1) ? 16'hAFFF : 16'hA000;
      end
    @(negedge clk);
    ox = 12'd8; oy = 12'd3; wm1 = 3; hm1 = 2;
    fmix = 7'h22; bmix = 7'h21; mask = 16'h0FFF; pc = 2'b10;
    run_cmd(0, 1, 0);
    check_mem("R6 destination-selected mix");
    check("R10 ready in mode 10", 16'(ready_seen), 16'd0);
    check("R9 mask output", wmask, 16'h0FFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule